// File: doc/BRIEF.md
# Frame Pulse Aligner with Sync Rate Auto-Detect

The block generates a one-cycle frame pulse train in its own clock domain and, when a valid external sync pulse is present, moves the phase of that train so that each frame pulse follows the sync rising edge by a fixed latency. Three sync inputs exist. The one in use is picked by the same select value that chooses the matching reference input elsewhere in the chip. The sync path only sets frame phase and never feeds any clock loop.

The selected sync is synchronized and edge-detected. The time between successive rising edges is counted in clock cycles and compared against six allowed frame rates. Each allowed period is an integer multiple of the parameter `BASE_CNT`, which is the cycle count of one 64 kHz frame. Two back-to-back periods of the same class qualify the sync. The frame counter then reloads on each qualifying edge. If no sync is qualified, the counter free-runs at a configured rate with arbitrary phase. The block falls back to free-run when sync edges stop or the select changes.

Top module: `frame_aligner`

## Requirements
- R1: While `rst` is high, `fp_out`, `sync_locked` and `sync_rate` are all 0 at every clock edge.
- R2: While unlocked, `fp_out` pulses once every P cycles. P is `BASE_CNT` times the multiplier of the rate picked by `free_rate`. Codes 0 and 7 select the 8 kHz rate.
- R3: Rate codes and period multipliers are 1 = 64 kHz (×1), 2 = 8 kHz (×8), 3 = 2 kHz (×32), 4 = 1 kHz (×64), 5 = 400 Hz (×160) and 6 = 166.67 Hz (×384). A period matches a code when it differs from the expected count by no more than floor(expected/100) cycles. With `BASE_CNT`=50, a period of 404 matches code 2 and a period of 405 matches nothing. Locking needs two consecutive periods with the same code. While locked, `sync_rate` holds that code and does not change. While unlocked, `sync_rate` is 0.
- R4: A sync is first sampled high at clock edge k. If that edge is qualifying (it completes two consecutive matching periods), `fp_out` is 1 after edge k+2, and `sync_locked`/`sync_rate` are updated at the same edge.
- R5: `fp_out` is high for exactly one cycle. While locked, one pulse occurs per sync edge and none in between.
- R6: Any duty cycle is accepted. A sync high for a single sampled cycle is captured as well as one held high for half the period.
- R7: Sync inputs other than the selected one have no effect on lock, rate or pulse phase. A `ref_sel` value of 3 selects no input.
- R8: If locked at rate period P and no selected sync edge arrives, `sync_locked` and `sync_rate` fall to 0 exactly 2P clock edges after the last qualifying edge was registered. Requalification then needs three new edges.
- R9: A change of `ref_sel` clears lock and detection state at the next clock edge. The newly selected sync must requalify from its first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and output clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel | input | 2 | Reference select; also picks the sync input |
| sync_in | input | 3 | Asynchronous sync frame pulse inputs |
| free_rate | input | 3 | Rate code used while unlocked |
| fp_out | output | 1 | One-cycle output frame pulse |
| sync_locked | output | 1 | Selected sync is qualified |
| sync_rate | output | 3 | Detected rate code, 0 when unlocked |

## Verification
A sync rise driven before clock edge k yields the qualified frame pulse and the lock and rate flags after edge k+2. A select change shows as a cleared lock after one edge. Loss of sync appears 2P edges after the last qualifying edge was registered. The driver records the cycle number at which it raises each sync and queues expected values stamped with these offsets. The monitor compares them only in the exact cycle, on the falling clock edge. Cycles where free-run phase is arbitrary carry expectations on lock and rate only, not on the pulse. Any expectation left unchecked or found late counts as a failure.

// File: rtl/fal_pkg.sv
package fal_pkg;

    localparam int NUM_SYNC = 3;

    typedef enum logic [2:0] {
        RATE_NONE = 3'd0,
        RATE_64K  = 3'd1,
        RATE_8K   = 3'd2,
        RATE_2K   = 3'd3,
        RATE_1K   = 3'd4,
        RATE_400  = 3'd5,
        RATE_166  = 3'd6
    } rate_e;

    typedef struct packed {
        logic  locked;
        rate_e rate;
    } lock_t;

    // frame length in units of one 64 kHz frame
    function automatic int unsigned rate_mult(rate_e r);
        case (r)
            RATE_64K: return 1;
            RATE_8K:  return 8;
            RATE_2K:  return 32;
            RATE_1K:  return 64;
            RATE_400: return 160;
            RATE_166: return 384;
            default:  return 0;
        endcase
    endfunction

    function automatic int unsigned rate_period(rate_e r, int unsigned base);
        return base * rate_mult(r);
    endfunction

    function automatic int unsigned rate_tol(rate_e r, int unsigned base);
        return rate_period(r, base) / 100;
    endfunction

    // windows do not overlap, so at most one code can hit
    function automatic rate_e classify(int unsigned meas, int unsigned base);
        rate_e       hit;
        int unsigned p;
        int unsigned t;
        int unsigned d;
        hit = RATE_NONE;
        for (int k = 1; k <= 6; k++) begin
            p = rate_period(rate_e'(3'(k)), base);
            t = p / 100;
            d = (meas >= p) ? meas - p : p - meas;
            if (d <= t) hit = rate_e'(3'(k));
        end
        return hit;
    endfunction

endpackage

// File: rtl/fal_edge_sync.sv
module fal_edge_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    // one synchronizer and edge detector per input, so switching the
    // select never fabricates an edge from a level difference
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic s1_q, s2_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= din[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end
        assign rise[i] = s2_q & ~prev_q;
    end
endmodule

// File: rtl/fal_rate_detect.sv
module fal_rate_detect
    import fal_pkg::*;
#(
    parameter int unsigned BASE_CNT = 300,
    parameter int          CNT_W    = 20
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  edge_in,
    output lock_t status,
    output logic  qual_edge
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             have_prev_q;
    rate_e            cand_q;
    lock_t            st_q;
    rate_e            meas_rate;
    logic             lost;

    always_comb begin
        meas_rate = classify(32'(cnt_q), BASE_CNT);
        qual_edge = edge_in && have_prev_q && (meas_rate != RATE_NONE)
                    && (meas_rate == cand_q);
        lost      = st_q.locked && !edge_in
                    && (32'(cnt_q) >= 2 * rate_period(st_q.rate, BASE_CNT));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q       <= '0;
            have_prev_q <= 1'b0;
            cand_q      <= RATE_NONE;
            st_q        <= '0;
        end else if (edge_in) begin
            cnt_q       <= CNT_W'(1);
            have_prev_q <= 1'b1;
            if (have_prev_q) begin
                cand_q <= meas_rate;
                if (qual_edge) begin
                    st_q.locked <= 1'b1;
                    st_q.rate   <= meas_rate;
                end else begin
                    st_q <= '0;
                end
            end
        end else begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (lost) begin
                st_q        <= '0;
                have_prev_q <= 1'b0;
                cand_q      <= RATE_NONE;
            end
        end
    end

    assign status = st_q;
endmodule

// File: rtl/fal_framer.sv
module fal_framer
    import fal_pkg::*;
#(
    parameter int unsigned BASE_CNT = 300,
    parameter int          CNT_W    = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       qual_edge,
    input  lock_t      status,
    input  logic [2:0] free_rate,
    output logic       fp_out
);
    logic [CNT_W-1:0] fcnt_q;
    logic             fp_q;
    rate_e            eff;
    int unsigned      limit;

    always_comb begin
        if (status.locked)                          eff = status.rate;
        else if (free_rate == 3'd0 || free_rate == 3'd7) eff = RATE_8K;
        else                                        eff = rate_e'(free_rate);
        // locked: stretch the wrap point by the tolerance so a late but
        // valid sync edge reloads the counter before it wraps on its own
        limit = rate_period(eff, BASE_CNT);
        if (status.locked) limit = limit + rate_tol(eff, BASE_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt_q <= CNT_W'(1);
            fp_q   <= 1'b0;
        end else if (qual_edge || (32'(fcnt_q) >= limit)) begin
            fcnt_q <= CNT_W'(1);
            fp_q   <= 1'b1;
        end else begin
            fcnt_q <= fcnt_q + 1'b1;
            fp_q   <= 1'b0;
        end
    end

    assign fp_out = fp_q;
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
    import fal_pkg::*;
#(
    parameter int unsigned BASE_CNT = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ref_sel,
    input  logic [2:0] sync_in,
    input  logic [2:0] free_rate,
    output logic       fp_out,
    output logic       sync_locked,
    output logic [2:0] sync_rate
);
    localparam int CNT_W = $clog2(BASE_CNT * 384 * 2 + 2) + 1;

    logic [NUM_SYNC-1:0] rise;
    logic                sel_edge;
    logic [1:0]          sel_q;
    logic                sel_change;
    logic                qual_edge;
    lock_t               status;

    fal_edge_sync #(.N(NUM_SYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_in),
        .rise (rise)
    );

    always_comb begin
        sel_edge = 1'b0;
        for (int i = 0; i < NUM_SYNC; i++)
            if (ref_sel == 2'(i)) sel_edge = rise[i];
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= ref_sel;
    end
    assign sel_change = (ref_sel != sel_q);

    fal_rate_detect #(.BASE_CNT(BASE_CNT), .CNT_W(CNT_W)) u_det (
        .clk       (clk),
        .rst       (rst),
        .clear     (sel_change),
        .edge_in   (sel_edge),
        .status    (status),
        .qual_edge (qual_edge)
    );

    fal_framer #(.BASE_CNT(BASE_CNT), .CNT_W(CNT_W)) u_frm (
        .clk       (clk),
        .rst       (rst),
        .qual_edge (qual_edge),
        .status    (status),
        .free_rate (free_rate),
        .fp_out    (fp_out)
    );

    assign sync_locked = status.locked;
    assign sync_rate   = status.rate;
endmodule

// File: rtl/frame_aligner_chk.sv
module frame_aligner_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ref_sel,
    input logic       sel_edge,
    input logic       fp_out,
    input logic       sync_locked,
    input logic [2:0] sync_rate
);
    AST_LOCK_RATE_VALID: assert property (@(posedge clk) disable iff (rst)
        sync_locked |-> (sync_rate != 3'd0 && sync_rate <= 3'd6)); // R3

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
        (sync_locked && $past(sync_locked)) |-> $stable(sync_rate)); // R3

    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_locked) |-> $past(sel_edge)); // R4

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (fp_out && sync_locked) |=> !fp_out); // R5

    AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ref_sel != $past(ref_sel)) |=> !sync_locked); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!fp_out && !sync_locked && sync_rate == 3'd0)); // R1
endmodule

bind frame_aligner frame_aligner_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_sel     (ref_sel),
    .sel_edge    (sel_edge),
    .fp_out      (fp_out),
    .sync_locked (sync_locked),
    .sync_rate   (sync_rate)
);

// File: tb/frame_aligner_bench.sv
module frame_aligner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ref_sel = 2'd0;
    logic [2:0] sync_in = 3'd0;
    logic [2:0] free_rate = 3'd1;
    logic       fp_out;
    logic       sync_locked;
    logic [2:0] sync_rate;

    frame_aligner #(.BASE_CNT(BASE)) u_frame_aligner (
        .clk         (clk),
        .rst         (rst),
        .ref_sel     (ref_sel),
        .sync_in     (sync_in),
        .free_rate   (free_rate),
        .fp_out      (fp_out),
        .sync_locked (sync_locked),
        .sync_rate   (sync_rate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        bit         cfp;
        bit         fp;
        bit         lk;
        logic [2:0] rate;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic check(bit ok, string req, string what, int act, int ex);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cyc, act, ex);
        end
    endtask

    task automatic push(int at, bit cfp, bit fp, bit lk, logic [2:0] rate, string req);
        exp_t e;
        e.at = at; e.cfp = cfp; e.fp = fp; e.lk = lk; e.rate = rate; e.req = req;
        q.push_back(e);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // monitor: compare queued expectations in their exact cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                if (q[i].cfp)
                    check(fp_out == q[i].fp, q[i].req, "fp_out", int'(fp_out), int'(q[i].fp));
                check(sync_locked == q[i].lk, q[i].req, "sync_locked",
                      int'(sync_locked), int'(q[i].lk));
                check(sync_rate == q[i].rate, q[i].req, "sync_rate",
                      int'(sync_rate), int'(q[i].rate));
                q.delete(i);
            end else if (q[i].at < cyc) begin
                check(1'b0, q[i].req, "stale expectation", q[i].at, cyc);
                q.delete(i);
            end
        end
    end

    // driver: raises sync ch every period cycles and queues the outcome;
    // lock_at is the edge index expected to qualify (-1: never)
    task automatic pulse_train(int ch, int period, int width, int count,
                               int lock_at, logic [2:0] rate, output int last_n);
        int n;
        @(negedge clk);
        for (int e = 0; e < count; e++) begin
            sync_in[ch] = 1'b1;
            n = cyc;
            last_n = n;
            if (lock_at >= 0 && e >= lock_at) begin
                push(n + 3, 1, 1, 1, rate, "R4");
                push(n + 4, 1, 0, 1, rate, "R5");
                if (e < count - 1) push(n + 3 + period / 2, 1, 0, 1, rate, "R5");
            end else if (e >= 1) begin
                push(n + 3, 0, 0, 0, 3'd0, "R3");
            end
            repeat (width) @(negedge clk);
            sync_in[ch] = 1'b0;
            if (e < count - 1) repeat (period - width) @(negedge clk);
        end
    endtask

    task automatic noise_ch0();
        for (int k = 0; k < 18; k++) begin
            sync_in[0] = 1'b1;
            repeat (3) @(negedge clk);
            sync_in[0] = 1'b0;
            repeat (74) @(negedge clk);
        end
    endtask

    task automatic reselect(logic [1:0] s);
        repeat (10) @(negedge clk);
        ref_sel = 2'd0;
        @(negedge clk);
        ref_sel = s;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int t1, t2, nl, m;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(fp_out == 1'b0, "R1", "fp_out", int'(fp_out), 0);
        check(sync_locked == 1'b0, "R1", "sync_locked", int'(sync_locked), 0);
        check(sync_rate == 3'd0, "R1", "sync_rate", int'(sync_rate), 0);
        rst = 1'b0;

        // R2: free-run spacing at code 1 is BASE cycles
        while (!fp_out) @(negedge clk);
        t1 = cyc;
        @(negedge clk);
        check(fp_out == 1'b0, "R5", "free-run width", int'(fp_out), 0);
        while (!fp_out) @(negedge clk);
        t2 = cyc;
        check(t2 - t1 == BASE, "R2", "free-run period", t2 - t1, BASE);
        check(sync_locked == 1'b0, "R2", "unlocked", int'(sync_locked), 0);

        // 8 kHz on channel 1 with single-cycle pulses; channel 0 noisy (R7)
        ref_sel = 2'd1;
        repeat (5) @(negedge clk);
        fork
            pulse_train(1, 8 * BASE, 1, 4, 2, 3'd2, nl);
            noise_ch0();
        join
        check(sync_locked == 1'b1, "R7", "lock kept despite ch0", int'(sync_locked), 1);
        check(sync_rate == 3'd2, "R7", "rate kept despite ch0", int'(sync_rate), 2);
        // R8: loss after 2P edges from the last qualifying edge
        push(nl + 3 + 2 * 8 * BASE - 1, 0, 0, 1, 3'd2, "R8");
        push(nl + 3 + 2 * 8 * BASE,     0, 0, 0, 3'd0, "R8");
        repeat (2 * 8 * BASE + 50) @(negedge clk);

        // R6: 50 percent duty at 64 kHz
        pulse_train(1, BASE, BASE / 2, 4, 2, 3'd1, nl);
        check(sync_rate == 3'd1, "R6", "wide pulse rate", int'(sync_rate), 1);

        // R9: select change clears lock at the next edge
        @(negedge clk);
        ref_sel = 2'd2;
        m = cyc;
        push(m + 1, 0, 0, 0, 3'd0, "R9");
        repeat (10) @(negedge clk);

        // R3: 405 is outside the 8 kHz window, 404 is inside
        pulse_train(2, 8 * BASE + 5, 1, 4, -1, 3'd0, nl);
        reselect(2'd2);
        pulse_train(2, 8 * BASE + 4, 1, 3, 2, 3'd2, nl);
        repeat (10) @(negedge clk);
        check(sync_rate == 3'd2, "R3", "edge of window", int'(sync_rate), 2);

        // R3: 2 kHz and 166.67 Hz codes
        reselect(2'd2);
        pulse_train(2, 32 * BASE, 1, 3, 2, 3'd3, nl);
        reselect(2'd2);
        pulse_train(2, 384 * BASE, 1, 3, 2, 3'd6, nl);

        repeat (20) @(negedge clk);
        check(q.size() == 0, "R4", "pending expectations", q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R4", "watchdog expired", cyc, 0);
            summary();
            $finish;
        end
    end

endmodule